// File: doc/BRIEF.md
# Triple Line Buffer Rotation Controller

This controller decides which of three (or more) scanline buffers a display engine reads and which one a line renderer writes. The display consumes exactly one line per end-of-line pulse and is never held back. The renderer fills lines in scanline order and signals each completed line. The controller tags every buffer with the scanline number it holds or is being filled with. At each display end-of-line it hands over the buffer tagged with the next scanline. When the display reaches that line before the renderer has finished it, the partly drawn buffer is handed over anyway, because the display cannot stall. The renderer is told to drop that line and start the one after it.

The renderer may work ahead while buffers are free. Once every buffer other than the displayed one holds a completed line, the renderer is idled until the display releases a buffer. Buffer contents are never cleared by this block. A line that is handed over unfinished therefore shows whatever pixels the buffer held from its previous use. Storage of the pixel data lies outside the block. Only the buffer indices and line numbers pass through it.

Top module: `tlb_rotator`

## Requirements
- R1: After reset the display owns buffer 0 showing line 0, the renderer owns buffer 1 working on line 1, `rend_go` is 1 and `rend_abort` is 0.
- R2: When `rend_done` is pulsed while `rend_go` is 1 and a buffer is free, the next cycle shows the renderer on the following line number, on a buffer that is neither displayed nor holding a completed line.
- R3: When every buffer except the displayed one holds a completed line, `rend_go` is 0 from the next cycle on, and `rend_done` pulses during that time change neither `rend_line` nor any buffer assignment.
- R4: On `disp_eol`, if the line after `disp_line` is complete, the next cycle shows `disp_buf` equal to the buffer the renderer held while finishing that line. Completed lines are shown in the order they were finished.
- R5: On `disp_eol`, if the needed line is still being rendered, the display takes the renderer's buffer. `rend_abort` is 1 for exactly that following cycle, and `rend_line` moves to the line after the one taken.
- R6: A `rend_done` and a `disp_eol` in the same cycle for the same line count as a completed line: no abort, and the display takes that buffer.
- R7: An idle renderer gets the buffer released by the display in the cycle after `disp_eol`, with `rend_go` back at 1 and `rend_line` unchanged.
- R8: Line numbers count from 0 to LINES-1 and then wrap to 0, both for the display and for the renderer.
- R9: The display never waits. Every `disp_eol` advances `disp_line` by one (with wrap), and without `disp_eol` both `disp_buf` and `disp_line` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_eol | input | 1 | Display finished its line; one-cycle pulse |
| rend_done | input | 1 | Renderer finished its current line; one-cycle pulse |
| disp_buf | output | $clog2(NBUF) | Buffer index the display reads |
| disp_line | output | $clog2(LINES) | Scanline number being displayed |
| rend_buf | output | $clog2(NBUF) | Buffer index the renderer writes (valid while rend_go) |
| rend_line | output | $clog2(LINES) | Scanline number the renderer must draw |
| rend_go | output | 1 | Renderer owns a buffer and may draw |
| rend_abort | output | 1 | One-cycle pulse: current line was taken, start rend_line afresh |

## Verification
The block is driven with a renderer running ahead until it idles, a display that outpaces the renderer so that lines are taken unfinished back to back, coincident completion and end-of-line pulses, and long alternating runs across the line-number wrap. The first pattern separates the idle rule from ordinary work-ahead. The second separates taking a ready buffer from stealing the one in progress. Coincident pulses show whether completion is processed ahead of handover. A scoreboard records which buffer each completed line was written into and compares it with the buffer the display shows for that line.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      ROLE_FREE  = 2'd0,
      ROLE_SHOW  = 2'd1,
      ROLE_READY = 2'd2,
      ROLE_FILL  = 2'd3
   } role_t;
endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
   parameter int             LW        = 9,
   parameter tlb_pkg::role_t INIT_ROLE = tlb_pkg::ROLE_FREE,
   parameter logic [LW-1:0]  INIT_TAG  = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  tlb_pkg::role_t d_role,
   input  logic [LW-1:0]  d_tag,
   output tlb_pkg::role_t q_role,
   output logic [LW-1:0]  q_tag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_role <= INIT_ROLE;
         q_tag  <= INIT_TAG;
      end else begin
         q_role <= d_role;
         q_tag  <= d_tag;
      end
   end
endmodule

// File: rtl/tlb_free_pick.sv
module tlb_free_pick #(
   parameter int N  = 3,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_line_find.sv
module tlb_line_find #(
   parameter int N  = 3,
   parameter int LW = 9,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]    mask,
   input  logic [N*LW-1:0] tags,
   input  logic [LW-1:0]   key,
   output logic            found,
   output logic [IW-1:0]   idx
);
   logic [N-1:0] hit;

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit[g] = mask[g] && (tags[g*LW +: LW] == key);
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (hit[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/tlb_rotator.sv
module tlb_rotator #(
   parameter int NBUF  = 3,
   parameter int LINES = 262,
   localparam int IW = $clog2(NBUF),
   localparam int LW = $clog2(LINES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          disp_eol,
   input  logic          rend_done,
   output logic [IW-1:0] disp_buf,
   output logic [LW-1:0] disp_line,
   output logic [IW-1:0] rend_buf,
   output logic [LW-1:0] rend_line,
   output logic          rend_go,
   output logic          rend_abort
);
   import tlb_pkg::*;

   if (NBUF < 3) begin : g_bad_nbuf
      $error("tlb_rotator: NBUF must be at least 3");
   end
   if (LINES <= NBUF) begin : g_bad_lines
      $error("tlb_rotator: LINES must exceed NBUF so line tags stay unique");
   end

   function automatic logic [LW-1:0] step_line(input logic [LW-1:0] l);
      return (l == LW'(LINES - 1)) ? '0 : l + 1'b1;
   endfunction

   role_t         role_q [NBUF];
   role_t         role_n [NBUF];
   logic [LW-1:0] tag_q  [NBUF];
   logic [LW-1:0] tag_n  [NBUF];

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      localparam role_t         R0 = (g == 0) ? ROLE_SHOW : ((g == 1) ? ROLE_FILL : ROLE_FREE);
      localparam logic [LW-1:0] T0 = (g == 1) ? LW'(1) : '0;
      tlb_slot #(.LW(LW), .INIT_ROLE(R0), .INIT_TAG(T0)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_role (role_n[g]),
         .d_tag  (tag_n[g]),
         .q_role (role_q[g]),
         .q_tag  (tag_q[g])
      );
   end

   logic [IW-1:0] disp_idx_q, disp_idx_n, rend_idx_q, rend_idx_n;
   logic [LW-1:0] disp_line_q, disp_line_n, rend_line_q, rend_line_n;
   logic          go_q, go_n, abort_q;

   logic [NBUF-1:0]    free_mask, cand_mask;
   logic [NBUF*LW-1:0] tag_flat;
   for (genvar g = 0; g < NBUF; g++) begin : g_mask
      assign free_mask[g]          = (role_q[g] == ROLE_FREE);
      assign cand_mask[g]          = (role_q[g] == ROLE_READY) || (role_q[g] == ROLE_FILL);
      assign tag_flat[g*LW +: LW]  = tag_q[g];
   end

   logic [LW-1:0] need_line;
   assign need_line = step_line(disp_line_q);

   logic          f_found, m_found;
   logic [IW-1:0] f_idx, m_idx;

   tlb_free_pick #(.N(NBUF)) u_free (
      .mask  (free_mask),
      .found (f_found),
      .idx   (f_idx)
   );

   tlb_line_find #(.N(NBUF), .LW(LW)) u_find (
      .mask  (cand_mask),
      .tags  (tag_flat),
      .key   (need_line),
      .found (m_found),
      .idx   (m_idx)
   );

   logic done_v, m_is_fill, abort_c, want;
   assign done_v    = rend_done && go_q;
   assign m_is_fill = (role_q[m_idx] == ROLE_FILL);
   assign abort_c   = disp_eol && m_found && m_is_fill && !done_v;

   always_comb begin
      for (int i = 0; i < NBUF; i++) begin
         role_n[i] = role_q[i];
         tag_n[i]  = tag_q[i];
      end
      disp_idx_n  = disp_idx_q;
      disp_line_n = disp_line_q;
      rend_idx_n  = rend_idx_q;
      rend_line_n = rend_line_q;
      go_n        = go_q;
      want        = 1'b0;

      // completion is processed before the handover of the same cycle
      if (done_v) begin
         role_n[rend_idx_q] = ROLE_READY;
         rend_line_n        = step_line(rend_line_q);
         want               = 1'b1;
      end

      if (disp_eol && m_found) begin
         role_n[disp_idx_q] = ROLE_FREE;
         role_n[m_idx]      = ROLE_SHOW;
         disp_idx_n         = m_idx;
         disp_line_n        = need_line;
         if (abort_c) begin
            rend_line_n = step_line(need_line);
            want        = 1'b1;
         end
      end

      if (disp_eol && !go_q) want = 1'b1;

      if (want) begin
         if (f_found) begin
            role_n[f_idx] = ROLE_FILL;
            tag_n[f_idx]  = rend_line_n;
            rend_idx_n    = f_idx;
            go_n          = 1'b1;
         end else if (disp_eol && m_found) begin
            role_n[disp_idx_q] = ROLE_FILL;
            tag_n[disp_idx_q]  = rend_line_n;
            rend_idx_n         = disp_idx_q;
            go_n               = 1'b1;
         end else begin
            go_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_idx_q  <= '0;
         disp_line_q <= '0;
         rend_idx_q  <= IW'(1);
         rend_line_q <= LW'(1);
         go_q        <= 1'b1;
         abort_q     <= 1'b0;
      end else begin
         disp_idx_q  <= disp_idx_n;
         disp_line_q <= disp_line_n;
         rend_idx_q  <= rend_idx_n;
         rend_line_q <= rend_line_n;
         go_q        <= go_n;
         abort_q     <= abort_c;
      end
   end

   assign disp_buf   = disp_idx_q;
   assign disp_line  = disp_line_q;
   assign rend_buf   = rend_idx_q;
   assign rend_line  = rend_line_q;
   assign rend_go    = go_q;
   assign rend_abort = abort_q;

   // R4: the needed line always exists as a ready or in-progress buffer
   p_need_found_r4: assert property (@(posedge clk) disable iff (!rst_n)
      disp_eol |-> m_found);

   // R9: display advances by exactly one line on every end-of-line
   p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
      disp_eol |=> (disp_line == step_line($past(disp_line))));

   // R9: without end-of-line the displayed buffer and line hold
   p_show_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_eol |=> ($stable(disp_buf) && $stable(disp_line)));

   // R2: the renderer never writes the displayed buffer
   p_distinct_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rend_go |-> (rend_buf != disp_buf));

   // R3: an idle renderer stays idle and ignores completion until end-of-line
   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rend_go && !disp_eol) |=> (!rend_go && $stable(rend_line)));

   // R5: an abort only follows an end-of-line
   p_abort_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rend_abort |-> $past(disp_eol));

   // R7: an idle renderer resumes right after end-of-line
   p_resume_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!rend_go && disp_eol) |=> (rend_go && $stable(rend_line)));
endmodule

// File: tb/test_tlb_rotator.sv
module test_tlb_rotator;
   localparam int CLK_PERIOD = 10;
   localparam int NBUF  = 3;
   localparam int LINES = 8;
   localparam int IW = $clog2(NBUF);
   localparam int LW = $clog2(LINES);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          disp_eol = 1'b0;
   logic          rend_done = 1'b0;
   logic [IW-1:0] disp_buf, rend_buf;
   logic [LW-1:0] disp_line, rend_line;
   logic          rend_go, rend_abort;

   int n_cmp = 0;
   int n_bad = 0;
   int lq[$];
   int bq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   tlb_rotator #(.NBUF(NBUF), .LINES(LINES)) i_tlb_rotator (
      .clk(clk), .rst_n(rst_n), .disp_eol(disp_eol), .rend_done(rend_done),
      .disp_buf(disp_buf), .disp_line(disp_line), .rend_buf(rend_buf),
      .rend_line(rend_line), .rend_go(rend_go), .rend_abort(rend_abort)
   );

   function automatic int nxt(input int l);
      return (l + 1) % LINES;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // driver + scoreboard: called at a negative edge
   task automatic cyc(input bit d, input bit e);
      int  rl, rb, dl, db, need, exp_buf, exp_rl;
      bit  go0, dv, exp_ab;
      rl = int'(rend_line); rb = int'(rend_buf);
      dl = int'(disp_line); db = int'(disp_buf); go0 = rend_go;
      dv = d && go0;
      need = nxt(dl);
      exp_buf = db; exp_ab = 1'b0; exp_rl = rl;
      if (dv) begin
         lq.push_back(rl);
         bq.push_back(rb);
         exp_rl = nxt(rl);
      end
      if (e) begin
         if (lq.size() > 0) begin
            chk(lq[0] == need, "R4 order", lq[0], need);
            exp_buf = bq[0];
            void'(lq.pop_front());
            void'(bq.pop_front());
         end else begin
            exp_buf = rb;
            exp_ab  = 1'b1;
            exp_rl  = nxt(need);
         end
      end
      rend_done = d;
      disp_eol  = e;
      @(posedge clk);
      @(negedge clk);
      rend_done = 1'b0;
      disp_eol  = 1'b0;
      // monitor
      if (e) begin
         chk(int'(disp_line) == need, "R9 line advance", int'(disp_line), need);
         chk(int'(disp_buf) == exp_buf, exp_ab ? "R5 steal buffer" : "R4 ready buffer",
             int'(disp_buf), exp_buf);
      end else begin
         chk(int'(disp_buf) == db && int'(disp_line) == dl, "R9 hold", int'(disp_buf), db);
      end
      chk(rend_abort == exp_ab, "R5 abort pulse", int'(rend_abort), int'(exp_ab));
      chk(rend_go == (lq.size() < NBUF - 1), "R3 go", int'(rend_go), int'(lq.size() < NBUF - 1));
      chk(int'(rend_line) == exp_rl, "R2 rend line", int'(rend_line), exp_rl);
      if (rend_go) begin
         bit clash;
         clash = (rend_buf == disp_buf);
         foreach (bq[k]) if (bq[k] == int'(rend_buf)) clash = 1'b1;
         chk(!clash, "R2 free buffer", int'(rend_buf), -1);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(disp_buf == 0 && disp_line == 0, "R1 display", int'(disp_buf), 0);
      chk(rend_buf == 1 && rend_line == 1, "R1 renderer", int'(rend_buf), 1);
      chk(rend_go == 1'b1 && rend_abort == 1'b0, "R1 flags", int'(rend_go), 1);
      // R2 work ahead, then R3 idle
      cyc(1, 0);
      cyc(1, 0);
      chk(rend_go == 1'b0, "R3 idle", int'(rend_go), 0);
      cyc(1, 0);   // R3 done while idle is ignored
      cyc(0, 1);   // R4 + R7 resume
      chk(rend_go == 1'b1 && rend_line == 3, "R7 resume", int'(rend_line), 3);
      cyc(0, 1);   // R4
      cyc(0, 1);   // R5 steal line 3
      chk(disp_line == 3 && rend_line == 4, "R5 skip", int'(rend_line), 4);
      cyc(1, 1);   // R6 same-cycle completion
      chk(rend_abort == 1'b0, "R6 no abort", int'(rend_abort), 0);
      cyc(0, 1);   // R5 again
      cyc(0, 1);   // R5 back to back
      // R8 wrap through alternating patterns
      for (int i = 0; i < 40; i++) begin
         cyc((i % 3) != 0, (i % 2) == 0);
      end
      for (int i = 0; i < 20; i++) cyc(1, 1);
      for (int i = 0; i < 12; i++) cyc(i < 6, i >= 4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule